// File: doc/BRIEF.md
# Microcoded Memory Cycle Sequencer

This block produces external memory bus cycles from a short program of 32-bit control words held in an internal word RAM. Each pending access names a target bank, whether it is a burst, the width of that bank's port, a starting low-order address and the RAM index where its program begins. Once an access is granted, the sequencer steps through consecutive words, one per clock. Each word sets the chip-select level of the target bank, whether the low-order address moves on, whether the data-valid strobe is driven, and whether the program ends.

Several request lanes can be pending at the same time. The lowest-numbered lane that is eligible wins. A word that ends a program can also arm a per-bank disable timer. That timer keeps the same bank from starting a new access for a programmable number of clocks, and leaves other banks free to proceed. A loader port fills the word RAM while the sequencer is idle.

Top module: `ucode_seq`

## Requirements
- R1: While idle (and in reset) every `cs_n` line is 1, `dvalid` is 0 and `busy` is 0.
- R2: While idle, or during a word with the last bit set, `req_ack` has one bit set: the lowest-numbered valid lane whose bank is not held by a disable timer. The first word of that lane's program executes in the next cycle, and `busy` stays 1 through its last word.
- R3: The word executed is at the lane's start index, then at index+1, index+2 and so on. Word fields are: bit 0 chip-select level, bit 28 address advance, bit 29 data valid, bit 30 timer arm, bit 31 last word. Bits 27..1 are unused.
- R4: `cs_n[b]` follows bit 0 of the current word only when b is the target bank and `bank_own[b]` is 1. Every other line stays at 1.
- R5: `dvalid` equals bit 29 of the word executing in the same cycle.
- R6: In a burst access `addr_out` starts at the lane's `req_addr`. In the cycle after a word with bit 28 set, it has advanced by 1, 2, 4 or 8 for `req_size` 0, 1, 2 or 3, wrapping modulo 2^AW.
- R7: In a non-burst access, bit 28 is ignored and `addr_out` holds `req_addr` for the whole program.
- R8: A last word ends the program. If an eligible lane is pending, its first word executes in the very next cycle, with no idle cycle between. Otherwise the block goes idle.
- R9: Bit 30 takes effect only together with bit 31. When it does, the same bank's next first word executes no earlier than `gap_cycles`+2 cycles after that last word, and exactly then if a request for that bank is waiting.
- R10: A running disable timer never delays another bank. A lane held by its timer does not stop a higher-numbered lane for a different bank from being granted.
- R11: Loader writes take effect only while `busy` is 0. A write presented while busy leaves the word RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bank_own | input | NBANK | Bank b's chip-select is driven by this sequencer when bit b is 1 |
| gap_cycles | input | TW | Disable timer length in cycles |
| req_valid | input | NREQ | Per-lane request pending |
| req_bank | input | NREQ*BW | Per-lane target bank |
| req_burst | input | NREQ | Per-lane burst flag |
| req_size | input | NREQ*2 | Per-lane port width code (0:8, 1:16, 2:32, 3:64 bit) |
| req_start | input | NREQ*IW | Per-lane program start index |
| req_addr | input | NREQ*AW | Per-lane initial low-order address |
| req_ack | output | NREQ | One-hot grant, combinational, in the decision cycle |
| ld_we | input | 1 | Loader write enable |
| ld_idx | input | IW | Loader word index |
| ld_word | input | 32 | Loader word data |
| cs_n | output | NBANK | Active-low chip-selects |
| addr_out | output | AW | Low-order address |
| dvalid | output | 1 | Data-valid strobe |
| busy | output | 1 | Program executing |

## Verification
`req_ack` is combinational and is sampled about 1 ns after the inputs change at the falling edge. `cs_n`, `dvalid` and `busy` describe the word executing in the cycle after the grant, and `addr_out` moves one cycle after an advancing word. The bench therefore steps through each program at successive falling edges and compares word k at the k-th falling edge after the grant. For the disable timer, the bench counts falling edges from the arming word until the same bank's chip-select falls, and expects `gap_cycles`+2. The loader test pokes the RAM mid-program and re-runs the same program afterwards, expecting unchanged output.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
  localparam int WB_LAST = 31;
  localparam int WB_TARM = 30;
  localparam int WB_DVAL = 29;
  localparam int WB_ADV  = 28;
  localparam int WB_CS   = 0;
  localparam int WORD_W  = 32;

  typedef enum logic [1:0] {
    PW8  = 2'd0,
    PW16 = 2'd1,
    PW32 = 2'd2,
    PW64 = 2'd3
  } port_w_e;

  function automatic logic [3:0] adv_step(input logic [1:0] pw);
    return 4'd1 << pw;
  endfunction
endpackage

// File: rtl/ucode_seq_wram.sv
module ucode_seq_wram #(
  parameter int DEPTH = 32,
  parameter int IW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] ridx,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[widx] <= wdata;
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/ucode_seq_arb.sv
module ucode_seq_arb #(
  parameter int NREQ  = 4,
  parameter int NBANK = 4,
  parameter int BW    = $clog2(NBANK)
) (
  input  logic              en,
  input  logic [NREQ-1:0]   valid,
  input  logic [NREQ*BW-1:0] bank,
  input  logic [NBANK-1:0]  held,
  output logic [NREQ-1:0]   ack,
  output logic              any
);
  logic [NREQ-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < NREQ; g++) begin : g_elig
      assign elig[g] = valid[g] & ~held[bank[g*BW +: BW]];
    end
  endgenerate

  always_comb begin
    ack = '0;
    any = 1'b0;
    for (int i = 0; i < NREQ; i++) begin
      if (en && !any && elig[i]) begin
        ack[i] = 1'b1;
        any    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ucode_seq_gap.sv
module ucode_seq_gap #(
  parameter int NBANK = 4,
  parameter int BW    = $clog2(NBANK),
  parameter int TW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic [BW-1:0]    arm_bank,
  input  logic [TW-1:0]    len,
  output logic [NBANK-1:0] running
);
  genvar b;
  generate
    for (b = 0; b < NBANK; b++) begin : g_bank
      logic [TW-1:0] cnt_q, cnt_d;
      logic          cnt_en;

      always_comb begin
        cnt_en = 1'b0;
        cnt_d  = cnt_q;
        if (arm && (arm_bank == BW'(b))) begin
          cnt_en = 1'b1;
          cnt_d  = len;
        end else if (cnt_q != '0) begin
          cnt_en = 1'b1;
          cnt_d  = cnt_q - 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_en) cnt_q <= cnt_d;
      end

      assign running[b] = (cnt_q != '0);
    end
  endgenerate
endmodule

// File: rtl/ucode_seq.sv
module ucode_seq
  import ucode_seq_pkg::*;
#(
  parameter int NREQ  = 4,
  parameter int NBANK = 4,
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int TW    = 6,
  localparam int BW   = $clog2(NBANK),
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NBANK-1:0]   bank_own,
  input  logic [TW-1:0]      gap_cycles,
  input  logic [NREQ-1:0]    req_valid,
  input  logic [NREQ*BW-1:0] req_bank,
  input  logic [NREQ-1:0]    req_burst,
  input  logic [NREQ*2-1:0]  req_size,
  input  logic [NREQ*IW-1:0] req_start,
  input  logic [NREQ*AW-1:0] req_addr,
  output logic [NREQ-1:0]    req_ack,
  input  logic               ld_we,
  input  logic [IW-1:0]      ld_idx,
  input  logic [WORD_W-1:0]  ld_word,
  output logic [NBANK-1:0]   cs_n,
  output logic [AW-1:0]      addr_out,
  output logic               dvalid,
  output logic               busy
);
  // reset: asserted asynchronously, released on a clock edge
  logic rs_meta_q, rs_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta_q <= 1'b0;
      rs_q      <= 1'b0;
    end else begin
      rs_meta_q <= 1'b1;
      rs_q      <= rs_meta_q;
    end
  end

  // sequencer state
  logic          act_q, act_d;
  logic [IW-1:0] pc_q, pc_d;
  logic [BW-1:0] bank_q, bank_d;
  logic          burst_q, burst_d;
  logic [1:0]    size_q, size_d;
  logic [AW-1:0] addr_q, addr_d;
  logic          seq_en;

  logic [WORD_W-1:0] word;
  logic              w_last, w_arm, w_adv;
  logic [NBANK-1:0]  t_run, bank_block;
  logic              arb_en, arb_any;

  ucode_seq_wram #(.DEPTH(DEPTH), .IW(IW), .DW(WORD_W)) u_wram (
    .clk   (clk),
    .we    (ld_we & ~act_q),
    .widx  (ld_idx),
    .wdata (ld_word),
    .ridx  (pc_q),
    .rdata (word)
  );

  assign w_last = act_q & word[WB_LAST];
  assign w_arm  = w_last & word[WB_TARM];
  assign w_adv  = act_q & burst_q & word[WB_ADV];

  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      bank_block[b] = t_run[b] | (w_arm && (bank_q == BW'(b)));
    end
  end

  assign arb_en = ~act_q | w_last;

  ucode_seq_arb #(.NREQ(NREQ), .NBANK(NBANK), .BW(BW)) u_arb (
    .en    (arb_en),
    .valid (req_valid),
    .bank  (req_bank),
    .held  (bank_block),
    .ack   (req_ack),
    .any   (arb_any)
  );

  ucode_seq_gap #(.NBANK(NBANK), .BW(BW), .TW(TW)) u_gap (
    .clk      (clk),
    .rst_n    (rs_q),
    .arm      (w_arm),
    .arm_bank (bank_q),
    .len      (gap_cycles),
    .running  (t_run)
  );

  // next state
  always_comb begin
    act_d   = act_q;
    pc_d    = pc_q;
    bank_d  = bank_q;
    burst_d = burst_q;
    size_d  = size_q;
    addr_d  = addr_q;
    if (arb_any) begin
      act_d = 1'b1;
      for (int i = 0; i < NREQ; i++) begin
        if (req_ack[i]) begin
          pc_d    = req_start[i*IW +: IW];
          bank_d  = req_bank[i*BW +: BW];
          burst_d = req_burst[i];
          size_d  = req_size[i*2 +: 2];
          addr_d  = req_addr[i*AW +: AW];
        end
      end
    end else if (w_last) begin
      act_d = 1'b0;
    end else if (act_q) begin
      pc_d = pc_q + 1'b1;
      if (w_adv) addr_d = addr_q + AW'(adv_step(size_q));
    end
  end

  assign seq_en = act_q | arb_any;

  always_ff @(posedge clk or negedge rs_q) begin
    if (!rs_q) begin
      act_q   <= 1'b0;
      pc_q    <= '0;
      bank_q  <= '0;
      burst_q <= 1'b0;
      size_q  <= PW8;
      addr_q  <= '0;
    end else if (seq_en) begin
      act_q   <= act_d;
      pc_q    <= pc_d;
      bank_q  <= bank_d;
      burst_q <= burst_d;
      size_q  <= size_d;
      addr_q  <= addr_d;
    end
  end

  // outputs
  always_comb begin
    for (int b = 0; b < NBANK; b++) begin
      cs_n[b] = (act_q && bank_own[b] && (bank_q == BW'(b))) ? word[WB_CS] : 1'b1;
    end
  end

  assign dvalid   = act_q & word[WB_DVAL];
  assign busy     = act_q;
  assign addr_out = addr_q;
endmodule

// File: rtl/ucode_seq_chk.sv
module ucode_seq_chk #(
  parameter int NREQ  = 4,
  parameter int NBANK = 4,
  parameter int AW    = 5,
  parameter int BW    = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic [NBANK-1:0]   cs_n,
  input logic               dvalid,
  input logic [NREQ-1:0]    req_ack,
  input logic [NREQ*BW-1:0] req_bank,
  input logic [NBANK-1:0]   bank_block,
  input logic [AW-1:0]      addr_out,
  input logic               burst_q,
  input logic               w_last
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> ((&cs_n) && !dvalid));

  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(req_ack));

  a_r4_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  a_r5_strobe_in_program: assert property (@(posedge clk) disable iff (!rst_n)
    dvalid |-> busy);

  a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !burst_q && !w_last) |=> $stable(addr_out));

  genvar g;
  generate
    for (g = 0; g < NREQ; g++) begin : g_lane
      a_r9_no_grant_held: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack[g] |-> !bank_block[req_bank[g*BW +: BW]]);
    end
  endgenerate
endmodule

bind ucode_seq ucode_seq_chk #(.NREQ(NREQ), .NBANK(NBANK), .AW(AW), .BW(BW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .cs_n       (cs_n),
  .dvalid     (dvalid),
  .req_ack    (req_ack),
  .req_bank   (req_bank),
  .bank_block (bank_block),
  .addr_out   (addr_out),
  .burst_q    (burst_q),
  .w_last     (w_last)
);

// File: tb/ucode_seq_bench.sv
`timescale 1ns/1ps
module ucode_seq_bench;
  localparam int NREQ = 4, NBANK = 4, DEPTH = 32, AW = 5, TW = 6;
  localparam int BW = 2, IW = 5;
  localparam int GAP = 3;
  localparam logic [3:0] OWN = 4'b0111;

  logic clk = 1'b0;
  logic rst_n;
  logic [NREQ-1:0]    rv;
  logic [NREQ*BW-1:0] rb;
  logic [NREQ-1:0]    rbu;
  logic [NREQ*2-1:0]  rsz;
  logic [NREQ*IW-1:0] rst_idx;
  logic [NREQ*AW-1:0] ra;
  logic [NREQ-1:0]    req_ack;
  logic               ld_we;
  logic [IW-1:0]      ld_idx;
  logic [31:0]        ld_word;
  logic [NBANK-1:0]   cs_n;
  logic [AW-1:0]      addr_out;
  logic               dvalid, busy;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ucode_seq #(.NREQ(NREQ), .NBANK(NBANK), .DEPTH(DEPTH), .AW(AW), .TW(TW)) u_ucode_seq (
    .clk(clk), .rst_n(rst_n), .bank_own(OWN), .gap_cycles(TW'(GAP)),
    .req_valid(rv), .req_bank(rb), .req_burst(rbu), .req_size(rsz),
    .req_start(rst_idx), .req_addr(ra), .req_ack(req_ack),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_word(ld_word),
    .cs_n(cs_n), .addr_out(addr_out), .dvalid(dvalid), .busy(busy)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_lane(input int i, input int b, input bit bu, input int sz,
                          input int st, input int ad);
    rv[i] = 1'b1;
    rb[i*BW +: BW] = BW'(b);
    rbu[i] = bu;
    rsz[i*2 +: 2] = 2'(sz);
    rst_idx[i*IW +: IW] = IW'(st);
    ra[i*AW +: AW] = AW'(ad);
  endtask

  task automatic load(input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_we = 1'b1; ld_idx = IW'(idx); ld_word = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  function automatic int exp_cs(input int bank, input int lvl);
    int v = 0;
    for (int b = 0; b < NBANK; b++) begin
      if (b == bank && OWN[b]) v |= (lvl << b);
      else v |= (1 << b);
    end
    return v;
  endfunction

  // Program A at index 0: 4 words, advance on words 0 and 1, strobe on 1..3
  task automatic run_a(input int lane, input int bank, input bit bu, input int sz,
                       input int init, input bit poke);
    int step = 1 << sz;
    int nadv = 0;
    @(negedge clk);
    set_lane(lane, bank, bu, sz, 0, init);
    #1 check("R2 grant", int'(req_ack), 1 << lane);
    @(negedge clk);
    rv[lane] = 1'b0;
    for (int k = 0; k < 4; k++) begin
      int ea = bu ? ((init + step * nadv) % 32) : init;
      check("R2 busy", int'(busy), 1);
      check("R3/R4 cs", int'(cs_n), exp_cs(bank, (k == 3) ? 1 : 0));
      check("R5 dvalid", int'(dvalid), (k == 0) ? 0 : 1);
      if (bu) check("R6 addr", int'(addr_out), ea);
      else    check("R7 addr", int'(addr_out), ea);
      if (k < 2) nadv++;
      if (poke && k == 1) begin ld_we = 1'b1; ld_idx = '0; ld_word = 32'hA000_0001; end
      if (poke && k == 2) ld_we = 1'b0;
      @(negedge clk);
    end
    check("R8 idle busy", int'(busy), 0);
    check("R1 idle cs", int'(cs_n), 15);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int found;
    rst_n = 1'b0;
    rv = '0; rb = '0; rbu = '0; rsz = '0; rst_idx = '0; ra = '0;
    ld_we = 1'b0; ld_idx = '0; ld_word = '0;
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(busy), 0);
    check("R1 reset cs", int'(cs_n), 15);
    check("R1 reset dvalid", int'(dvalid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 idle after reset", int'(busy), 0);

    load(0, 32'h1000_0000);
    load(1, 32'h3000_0000);
    load(2, 32'h2000_0000);
    load(3, 32'hB000_0001);
    load(8, 32'hE000_0000);
    load(12, 32'h4000_0000);
    load(13, 32'hA000_0001);

    // R6, R7, R4, R11: sweep bank, burst, width; first run pokes the RAM
    for (int bank = 0; bank < 4; bank++)
      for (int bu = 0; bu < 2; bu++)
        for (int sz = 0; sz < 4; sz++)
          run_a(bank, bank, bit'(bu), sz, (bank * 9 + sz * 7 + 20) % 32,
                (bank == 0 && bu == 0 && sz == 0));

    // R11: word 0 still as loaded before the busy-time write
    run_a(0, 0, 1'b1, 3, 30, 1'b0);

    // R2 priority, R8 back-to-back, R4 unowned bank 3
    @(negedge clk);
    set_lane(2, 3, 1'b0, 0, 8, 0);
    set_lane(3, 0, 1'b0, 0, 8, 0);
    #1 check("R2 lowest lane", int'(req_ack), 4);
    @(negedge clk);
    rv[2] = 1'b0;
    check("R4 unowned bank", int'(cs_n), 15);
    check("R5 strobe", int'(dvalid), 1);
    #1 check("R8 grant at last word", int'(req_ack), 8);
    @(negedge clk);
    rv[3] = 1'b0;
    check("R8 no idle gap", int'(cs_n), 14);
    @(negedge clk);
    check("R8 idle", int'(busy), 0);
    repeat (8) @(negedge clk);

    // R9, R10: armed timer on bank 1, bank 2 served meanwhile
    @(negedge clk);
    set_lane(0, 1, 1'b0, 0, 8, 0);
    #1 check("R2 grant lane0", int'(req_ack), 1);
    @(negedge clk);
    set_lane(1, 2, 1'b0, 0, 8, 0);
    #1 check("R10 bypass held lane", int'(req_ack), 2);
    @(negedge clk);
    rv[1] = 1'b0;
    check("R10 other bank runs", int'(cs_n), 11);
    found = -1;
    for (int c = 2; c <= 12; c++) begin
      @(negedge clk);
      if (found < 0 && cs_n[1] == 1'b0) begin
        found = c;
        rv[0] = 1'b0;
      end
    end
    check("R9 timer gap", found, GAP + 2);
    repeat (6) @(negedge clk);

    // R9: timer bit without last word is ignored
    @(negedge clk);
    set_lane(0, 0, 1'b0, 0, 12, 0);
    #1 check("R2 grant", int'(req_ack), 1);
    @(negedge clk);
    check("R3 word 12", int'(cs_n), 14);
    @(negedge clk);
    check("R3 word 13", int'(cs_n), 15);
    #1 check("R9 arm without last ignored", int'(req_ack), 1);
    @(negedge clk);
    rv[0] = 1'b0;
    check("R8 restart", int'(cs_n), 14);
    @(negedge clk);
    @(negedge clk);
    check("R8 idle end", int'(busy), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule